// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block gathers interrupt sources for a peripheral into one register bank that software can service without read-modify-write sequences. Hardware raises single-cycle event pulses on a vector input, and each pulse latches into a pending-cause bit. Software can also post causes itself by writing ones to a cause-post address. A read of the cause address returns every pending bit and clears all of them in the same operation. A bit whose event arrives in the same cycle as that read stays pending.

The enable mask is never written as a whole word. One address turns on the mask bits written as 1 and another turns them off, so two agents that each change their own bits do not interfere. Reading the mask-on address returns the current mask. A registered level interrupt line is high whenever a pending cause meets an enabled mask bit. The register port is synchronous: address, write strobe, write data and read strobe, with read data returned in the following cycle.

Top module: `irq_cause_mask_bank`

## Requirements
- R1: After a synchronous active-low reset, all cause bits and all mask bits are 0, `irq` is 0 and `rd_data` is 0.
- R2: A read (`rd_en`=1) at address 0 (cause-read) returns the pending causes on `rd_data` in the next cycle and clears every bit that was pending. In any cycle after a cycle without `rd_en`, `rd_data` is 0.
- R3: An `hw_event` bit that is 1 in the same cycle as a cause-read leaves that cause bit set after the read.
- R4: A write (`wr_en`=1) at address 1 (cause-post) sets each cause bit whose `wr_data` bit is 1 and leaves the other bits unchanged.
- R5: An `hw_event` bit sets its cause bit whatever the value of the matching mask bit.
- R6: A write at address 2 (mask-on) sets each mask bit whose `wr_data` bit is 1. A write at address 3 (mask-off) clears each mask bit whose `wr_data` bit is 1. Mask bits written as 0 keep their value.
- R7: A read at address 2 returns the current mask in the next cycle and does not change the mask.
- R8: Reads at addresses 1 and 3 return 0 and change no state. Writes to address 0 are ignored.
- R9: `irq` is a register. In each cycle it equals the OR over all bits of (cause AND mask) taken from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_event | input | WIDTH | Single-cycle hardware event pulses, one per cause bit |
| addr | input | 2 | Word address: 0 cause-read, 1 cause-post, 2 mask-on/read, 3 mask-off |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WIDTH | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is an event pulse on a pending bit that arrives in exactly the cycle the clearing read is sampled. If it does not line up exactly, the case reduces to an ordinary clear or an ordinary set. A directed sequence first makes a bit pending. It then presents the cause-read together with an event on that same bit, and a second read confirms the bit survived. The random phase drives sparse event vectors alongside frequent cause-reads, which produces many more of these collisions on assorted bits. Every read result is compared with a bench model.

// File: rtl/irq_bank_pkg.sv
// Package: shared address map and decoded strobe type for the interrupt bank.
// Assumes a two-bit word address; the address values are fixed by the register map.
package irq_bank_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CAUSE_RD  = 2'd0,
        REG_CAUSE_SET = 2'd1,
        REG_MASK_SET  = 2'd2,
        REG_MASK_CLR  = 2'd3
    } irq_reg_e;

    typedef struct packed {
        logic cause_rd;   // clearing read of causes
        logic cause_set;  // software post of causes
        logic mask_set;   // write-one-to-set mask
        logic mask_clr;   // write-one-to-clear mask
        logic mask_rd;    // non-destructive mask read
    } irq_strobe_t;
endpackage

// File: rtl/irq_addr_decode.sv
// Module: turns the register port strobes and address into one-hot operation strobes.
// Assumes wr_en and rd_en share the single address; writes to the cause-read
// address and reads of write-only addresses decode to no operation.
module irq_addr_decode
    import irq_bank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output irq_strobe_t       stb
);
    irq_reg_e reg_sel;

    // Purpose: map address to register select and qualify by strobe.
    always_comb begin
        reg_sel       = irq_reg_e'(addr);
        stb           = '0;
        stb.cause_rd  = rd_en && (reg_sel == REG_CAUSE_RD);
        stb.cause_set = wr_en && (reg_sel == REG_CAUSE_SET);
        stb.mask_set  = wr_en && (reg_sel == REG_MASK_SET);
        stb.mask_clr  = wr_en && (reg_sel == REG_MASK_CLR);
        stb.mask_rd   = rd_en && (reg_sel == REG_MASK_SET);
    end
endmodule

// File: rtl/irq_cause_reg.sv
// Module: pending-cause register, one cell per bit.
// Each bit sets from a hardware pulse or a software post and clears on a
// cause-read; setting wins over the clear, so no event can be lost.
module irq_cause_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] hw_event,
    input  logic             post_stb,
    input  logic [WIDTH-1:0] post_data,
    input  logic             clear_stb,
    output logic [WIDTH-1:0] cause_q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic set_bit;
        assign set_bit = hw_event[i] | (post_stb & post_data[i]);

        // Purpose: hold one pending cause; set has priority over read-clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cause_q[i] <= 1'b0;
            end else begin
                cause_q[i] <= set_bit | (cause_q[i] & ~clear_stb);
            end
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Module: interrupt enable mask, changed only by write-one-to-set and
// write-one-to-clear operations. Assumes both strobes are never active together
// (they decode from different addresses of one port).
module irq_mask_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_stb,
    input  logic             clr_stb,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] mask_q
);
    logic [WIDTH-1:0] set_vec;
    logic [WIDTH-1:0] clr_vec;

    // Purpose: gate the write data into set and clear vectors.
    always_comb begin
        set_vec = set_stb ? wdata : '0;
        clr_vec = clr_stb ? wdata : '0;
    end

    // Purpose: apply the set and clear vectors to the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= (mask_q | set_vec) & ~clr_vec;
        end
    end
endmodule

// File: rtl/irq_out_stage.sv
// Module: registered read-data mux and interrupt line.
// Read data is zero in any cycle not following a read of a readable address.
module irq_out_stage
    import irq_bank_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  irq_strobe_t      stb,
    input  logic [WIDTH-1:0] cause_q,
    input  logic [WIDTH-1:0] mask_q,
    output logic [WIDTH-1:0] rd_data,
    output logic             irq
);
    logic [WIDTH-1:0] rd_mux;

    // Purpose: select the readable register for the current read.
    always_comb begin
        if (stb.cause_rd) begin
            rd_mux = cause_q;
        end else if (stb.mask_rd) begin
            rd_mux = mask_q;
        end else begin
            rd_mux = '0;
        end
    end

    // Purpose: register read data and the unmasked-pending interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            irq     <= 1'b0;
        end else begin
            rd_data <= rd_mux;
            irq     <= |(cause_q & mask_q);
        end
    end
endmodule

// File: rtl/irq_cause_mask_bank.sv
// Module: top of the interrupt cause/mask bank.
// Assumes hw_event bits are single-cycle pulses synchronous to clk.
module irq_cause_mask_bank
    import irq_bank_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  hw_event,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              rd_en,
    output logic [WIDTH-1:0]  rd_data,
    output logic              irq
);
    irq_strobe_t      stb;
    logic [WIDTH-1:0] cause_q;
    logic [WIDTH-1:0] mask_q;

    irq_addr_decode u_dec (
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .stb   (stb)
    );

    irq_cause_reg #(.WIDTH(WIDTH)) u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_event  (hw_event),
        .post_stb  (stb.cause_set),
        .post_data (wr_data),
        .clear_stb (stb.cause_rd),
        .cause_q   (cause_q)
    );

    irq_mask_reg #(.WIDTH(WIDTH)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (stb.mask_set),
        .clr_stb (stb.mask_clr),
        .wdata   (wr_data),
        .mask_q  (mask_q)
    );

    irq_out_stage #(.WIDTH(WIDTH)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (stb),
        .cause_q (cause_q),
        .mask_q  (mask_q),
        .rd_data (rd_data),
        .irq     (irq)
    );
endmodule

// File: rtl/irq_cause_mask_bank_chk.sv
// Module: property checker for irq_cause_mask_bank, attached by bind below.
module irq_cause_mask_bank_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] hw_event,
    input logic [1:0]       addr,
    input logic             wr_en,
    input logic [WIDTH-1:0] wr_data,
    input logic             rd_en,
    input logic [WIDTH-1:0] rd_data,
    input logic             irq,
    input logic [WIDTH-1:0] cause_q,
    input logic [WIDTH-1:0] mask_q
);
    // R1: outputs are quiet in the cycle after reset is applied
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0) && !irq);

    // R2: no read strobe means zero read data next cycle
    assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rd_data == '0);

    // R3: an event bit is pending afterwards even if a clearing read collided
    assert_event_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_event) |=> ((cause_q & $past(hw_event)) == $past(hw_event)));

    // R4: software post sets the written bits
    assert_cause_post_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1) |=> ((cause_q & $past(wr_data)) == $past(wr_data)));

    // R6: mask-on sets and mask-off clears the written bits
    assert_mask_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd2) |=> ((mask_q & $past(wr_data)) == $past(wr_data)));
    assert_mask_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3) |=> ((mask_q & $past(wr_data)) == '0));

    // R7: mask read is non-destructive
    assert_mask_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == 2'd2) |=> (mask_q == $past(mask_q)) && (rd_data == $past(mask_q)));

    // R8: reads of write-only addresses return zero
    assert_wo_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[0]) |=> rd_data == '0);

    // R9: irq follows unmasked pending causes one cycle later
    assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == |($past(cause_q) & $past(mask_q))));
endmodule

bind irq_cause_mask_bank irq_cause_mask_bank_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_event (hw_event),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .irq      (irq),
    .cause_q  (cause_q),
    .mask_q   (mask_q)
);

// File: tb/irq_cause_mask_bank_tb.sv
// Bench: directed corner cases plus seeded random traffic against a bench model.
module irq_cause_mask_bank_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] hw_event = '0;
    logic [1:0]   addr = '0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic [W-1:0] rd_data;
    logic         irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [W-1:0] m_cause = '0;
    logic [W-1:0] m_mask  = '0;

    always #2.5 clk = ~clk;  // 200 MHz

    irq_cause_mask_bank #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .hw_event(hw_event), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [W-1:0] f_cause(logic [W-1:0] c, logic [W-1:0] ev,
                                             logic [1:0] a, logic we, logic re,
                                             logic [W-1:0] wd);
        logic [W-1:0] n = c;
        if (re && a == 2'd0) n = '0;
        if (we && a == 2'd1) n = n | wd;
        return n | ev;
    endfunction

    function automatic logic [W-1:0] f_mask(logic [W-1:0] m, logic [1:0] a,
                                            logic we, logic [W-1:0] wd);
        if (we && a == 2'd2) return m | wd;
        if (we && a == 2'd3) return m & ~wd;
        return m;
    endfunction

    function automatic logic [W-1:0] f_rd(logic [W-1:0] c, logic [W-1:0] m,
                                          logic [1:0] a, logic re);
        if (!re) return '0;
        if (a == 2'd0) return c;
        if (a == 2'd2) return m;
        return '0;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, step model at posedge, check at next negedge.
    task automatic cyc(string req, logic [W-1:0] ev, logic [1:0] a, logic we,
                       logic re, logic [W-1:0] wd);
        logic [W-1:0] e_rd;
        logic         e_irq;
        hw_event = ev; addr = a; wr_en = we; rd_en = re; wr_data = wd;
        e_rd  = f_rd(m_cause, m_mask, a, re);
        e_irq = |(m_cause & m_mask);
        @(posedge clk);
        m_cause = f_cause(m_cause, ev, a, we, re, wd);
        m_mask  = f_mask(m_mask, a, we, wd);
        @(negedge clk);
        check({req, " rd_data"}, rd_data, e_rd);
        check("R9 irq", {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, e_irq});
    endtask

    task automatic idle(string req);
        cyc(req, '0, 2'd0, 1'b0, 1'b0, '0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check("R1 rd_data", rd_data, '0);
        check("R1 irq", {{(W-1){1'b0}}, irq}, '0);
        rst_n = 1'b1;
        // R1: registers read as zero after reset
        cyc("R1 cause", '0, 2'd0, 1'b0, 1'b1, '0);
        cyc("R1 mask", '0, 2'd2, 1'b0, 1'b1, '0);

        // R5: event latches with mask all zero; R2 read clears it
        cyc("R5", 32'h0000_0100, 2'd0, 1'b0, 1'b0, '0);
        cyc("R5 R2 cause-read", '0, 2'd0, 1'b0, 1'b1, '0);
        cyc("R2 cleared", '0, 2'd0, 1'b0, 1'b1, '0);

        // R3: event colliding with clearing read is kept
        cyc("R3 setup", 32'h0000_0008, 2'd0, 1'b0, 1'b0, '0);
        cyc("R3 collide", 32'h0000_0018, 2'd0, 1'b0, 1'b1, '0);
        cyc("R3 kept", '0, 2'd0, 1'b0, 1'b1, '0);

        // R4: software post only sets 1 bits
        cyc("R4 post", '0, 2'd1, 1'b1, 1'b0, 32'hA000_0001);
        cyc("R4 post2", '0, 2'd1, 1'b1, 1'b0, 32'h0000_0000);
        cyc("R4 read", '0, 2'd0, 1'b0, 1'b1, '0);

        // R6 / R7: mask on/off and non-destructive read
        cyc("R6 on", '0, 2'd2, 1'b1, 1'b0, 32'hF0F0_00FF);
        cyc("R6 off", '0, 2'd3, 1'b1, 1'b0, 32'h00F0_000F);
        cyc("R7 read", '0, 2'd2, 1'b0, 1'b1, '0);
        cyc("R7 reread", '0, 2'd2, 1'b0, 1'b1, '0);

        // R9: masked-on event raises irq two cycles after the pulse
        cyc("R9 event", 32'h0000_0010, 2'd0, 1'b0, 1'b0, '0);
        idle("R9 wait");
        idle("R9 hold");
        cyc("R9 clear", '0, 2'd0, 1'b0, 1'b1, '0);
        idle("R9 drop");

        // R8: write-only reads return zero; write to cause-read ignored
        cyc("R8 post", '0, 2'd1, 1'b1, 1'b0, 32'h0000_0C00);
        cyc("R8 rd set-addr", '0, 2'd1, 1'b0, 1'b1, '0);
        cyc("R8 rd clr-addr", '0, 2'd3, 1'b0, 1'b1, '0);
        cyc("R8 wr cause-rd", '0, 2'd0, 1'b1, 1'b0, 32'hFFFF_FFFF);
        cyc("R8 unchanged", '0, 2'd0, 1'b0, 1'b1, '0);
        cyc("R8 mask kept", '0, 2'd2, 1'b0, 1'b1, '0);

        // Random traffic covering R2..R9
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] ev;
            logic [1:0]   a;
            logic         we;
            logic         re;
            ev = (($urandom % 4) == 0) ? ($urandom & $urandom & $urandom) : '0;
            a  = 2'($urandom % 4);
            re = ($urandom % 2) == 1;
            we = ($urandom % 3) == 0;
            if (a == 2'd0) re = re | (($urandom % 2) == 1);
            cyc("R2 R3 R4 R6 R7 R8 random", ev, a, we, re, $urandom & $urandom);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule